// File: doc/BRIEF.md
# Floating-Point Exception Flag and Mask Controller

This block keeps the control word of a floating-point unit together with the exception half of its status word. The arithmetic and stack logic report each exception as a one-cycle pulse, one line per class, plus a separate stack-fault line. Every pulse sets a sticky flag. A flag stays set until software clears the flags or the unit is initialised.

Each class also has a mask bit in the control word. When the mask bit is set, the exception is handled quietly: in the cycle of the event, the block asserts a per-class strobe that tells the datapath to substitute its default result, for example an infinity for a division by zero. When the mask bit is clear, the block raises an interrupt request. The request stays asserted until the handler acknowledges it, and the acknowledge only takes effect once no unmasked flag is left.

The block has a control-word write port, read views of the control and status words, an initialise command, a clear-exceptions command and an interrupt acknowledge. The rounding-mode field of the control word is brought out separately for the datapath.

Top module: `fpx_guard`

## Requirements
- R1: On reset, and on the edge after `init_cmd` is sampled, `ctl_word` becomes 16'h037F and `stat_word` becomes 16'h0000. This masks all six classes, selects rounding mode 0 and leaves `irq_req` low.
- R2: An `evt_pulse` bit sampled at an edge sets the matching `stat_word` bit after that edge. The bit order is: 0 invalid operation, 1 denormal operand, 2 zero divide, 3 overflow, 4 underflow, 5 precision. Flags are sticky: new events are ORed into them and never clear them.
- R3: A pulse on `evt_stack_fault` sets `stat_word` bit 6 and also sets the invalid-operation flag in bit 0.
- R4: `clear_cmd` zeroes `stat_word` bits 6:0 at the next edge and leaves the interrupt request bit unchanged. An event sampled in the same cycle as the clear still sets its flag.
- R5: When the mask bit for class i is set (`ctl_word` bit i = 1), an event on class i drives `subst_default` bit i high in the same cycle and does not raise `irq_req`. A stack fault counts as an invalid-operation event for this purpose.
- R6: When the mask bit for class i is clear, an event on class i leaves `subst_default` bit i low. `irq_req` goes high after the edge that captures the event.
- R7: A control-word write is visible on `ctl_word` after the edge that samples it. `round_mode` always equals `ctl_word` bits 11:10. If a write clears the mask bit of a flag that is already set, `irq_req` goes high after that same edge.
- R8: `irq_ack` clears `irq_req` only when no set flag has a clear mask bit after the edge. Otherwise the acknowledge is ignored. Once raised, `irq_req` stays high until such an acknowledge or until initialisation, even if the flags are cleared or masked.
- R9: When `init_cmd` is asserted in the same cycle as a control write, a clear, events or an acknowledge, initialisation takes precedence.
- R10: `stat_word` bit 7 always equals `irq_req`, and bits 15:8 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_cmd | input | 1 | Initialise the control and status words |
| clear_cmd | input | 1 | Clear the exception flags and the stack-fault flag |
| irq_ack | input | 1 | Handler-complete acknowledge |
| ctl_wr_en | input | 1 | Control-word write strobe |
| ctl_wr_data | input | 16 | Control-word write data |
| evt_pulse | input | 6 | One-cycle exception event pulses, one per class |
| evt_stack_fault | input | 1 | One-cycle stack-fault event pulse |
| ctl_word | output | 16 | Current control word |
| stat_word | output | 16 | Exception part of the status word |
| round_mode | output | 2 | Rounding-mode field of the control word |
| subst_default | output | 6 | Per-class strobe to substitute the default result for a masked event |
| irq_req | output | 1 | Interrupt request for an unmasked exception |

## Verification
The bench builds the block with its default parameters: six exception classes, a 16-bit word and the reset control word 037Fh. These defaults make every class reachable one at a time under its real mask bit, along with the stack-fault bit at position 6 and the request bit at position 7. The directed scenarios cover:
- a masked event versus an unmasked event on the same class;
- unmasking a class whose flag is already set;
- an acknowledge that arrives while an unmasked flag is still set, and one that arrives after the flags are gone;
- a cycle that combines initialise, write, clear and events.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  // Status word positions outside the per-class flag field
  localparam int unsigned STK_FAULT_POS = 6;
  localparam int unsigned IRQ_POS       = 7;
  // Rounding-mode field position in the control word
  localparam int unsigned RND_LSB       = 10;
  localparam int unsigned RND_W         = 2;
  // Class that a stack fault also reports
  localparam int unsigned INVALID_POS   = 0;

  // Update action applied to every sticky flag in one cycle
  typedef enum logic [1:0] {
    FLG_KEEP  = 2'd0,
    FLG_CLEAR = 2'd1,
    FLG_INIT  = 2'd2
  } flag_upd_e;
endpackage

// File: rtl/fpx_ctl_reg.sv
module fpx_ctl_reg #(
  parameter int unsigned WORD_W = 16,
  parameter logic [WORD_W-1:0] RESET_VAL = 16'h037F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] q_o,
  output logic [WORD_W-1:0] q_nxt_o
);
  logic              cw_en;
  logic [WORD_W-1:0] cw_nxt;
  logic [WORD_W-1:0] cw_q;

  always_comb begin
    cw_en  = init_i | wr_en_i;
    cw_nxt = cw_q;
    if (init_i) begin
      cw_nxt = RESET_VAL;
    end else if (wr_en_i) begin
      cw_nxt = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q <= RESET_VAL;
    end else if (cw_en) begin
      cw_q <= cw_nxt;
    end
  end

  assign q_o     = cw_q;
  assign q_nxt_o = cw_nxt;
endmodule

// File: rtl/fpx_flag_bank.sv
module fpx_flag_bank
  import fpx_pkg::*;
#(
  parameter int unsigned N_EXC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  flag_upd_e        upd_i,
  input  logic [N_EXC-1:0] evt_i,
  input  logic             sf_evt_i,
  output logic [N_EXC-1:0] flags_o,
  output logic [N_EXC-1:0] flags_nxt_o,
  output logic             sf_o
);
  localparam int unsigned CELLS = N_EXC + 1;

  logic [CELLS-1:0] set_vec;
  logic [CELLS-1:0] cell_q;
  logic [CELLS-1:0] cell_nxt;

  always_comb begin
    set_vec              = {sf_evt_i, evt_i};
    set_vec[INVALID_POS] = evt_i[INVALID_POS] | sf_evt_i;
  end

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    logic en;
    always_comb begin
      en = (upd_i != FLG_KEEP) | set_vec[g];
      unique case (upd_i)
        FLG_INIT:  cell_nxt[g] = 1'b0;
        FLG_CLEAR: cell_nxt[g] = set_vec[g];
        default:   cell_nxt[g] = cell_q[g] | set_vec[g];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[g] <= 1'b0;
      end else if (en) begin
        cell_q[g] <= cell_nxt[g];
      end
    end
  end

  assign flags_o     = cell_q[N_EXC-1:0];
  assign flags_nxt_o = cell_nxt[N_EXC-1:0];
  assign sf_o        = cell_q[N_EXC];
endmodule

// File: rtl/fpx_irq_ctl.sv
module fpx_irq_ctl #(
  parameter int unsigned N_EXC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             ack_i,
  input  logic [N_EXC-1:0] flags_nxt_i,
  input  logic [N_EXC-1:0] mask_nxt_i,
  output logic             irq_o
);
  logic pend_nxt;
  logic irq_nxt;
  logic irq_q;

  always_comb begin
    pend_nxt = |(flags_nxt_i & ~mask_nxt_i);
    if (init_i) begin
      irq_nxt = 1'b0;
    end else if (pend_nxt) begin
      irq_nxt = 1'b1;
    end else if (ack_i) begin
      irq_nxt = 1'b0;
    end else begin
      irq_nxt = irq_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_nxt;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/fpx_guard.sv
module fpx_guard
  import fpx_pkg::*;
#(
  parameter int unsigned N_EXC = 6,
  parameter int unsigned WORD_W = 16,
  parameter logic [WORD_W-1:0] CW_RESET = 16'h037F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_cmd,
  input  logic              clear_cmd,
  input  logic              irq_ack,
  input  logic              ctl_wr_en,
  input  logic [WORD_W-1:0] ctl_wr_data,
  input  logic [N_EXC-1:0]  evt_pulse,
  input  logic              evt_stack_fault,
  output logic [WORD_W-1:0] ctl_word,
  output logic [WORD_W-1:0] stat_word,
  output logic [RND_W-1:0]  round_mode,
  output logic [N_EXC-1:0]  subst_default,
  output logic              irq_req
);
  logic [WORD_W-1:0] cw_q;
  logic [WORD_W-1:0] cw_nxt;
  logic [N_EXC-1:0]  flags;
  logic [N_EXC-1:0]  flags_nxt;
  logic              sf_flag;
  logic              irq_q;
  flag_upd_e         upd;
  logic [N_EXC-1:0]  evt_eff;

  always_comb begin
    if (init_cmd) begin
      upd = FLG_INIT;
    end else if (clear_cmd) begin
      upd = FLG_CLEAR;
    end else begin
      upd = FLG_KEEP;
    end
  end

  fpx_ctl_reg #(.WORD_W(WORD_W), .RESET_VAL(CW_RESET)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_i    (init_cmd),
    .wr_en_i   (ctl_wr_en),
    .wr_data_i (ctl_wr_data),
    .q_o       (cw_q),
    .q_nxt_o   (cw_nxt)
  );

  fpx_flag_bank #(.N_EXC(N_EXC)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_i       (upd),
    .evt_i       (evt_pulse),
    .sf_evt_i    (evt_stack_fault),
    .flags_o     (flags),
    .flags_nxt_o (flags_nxt),
    .sf_o        (sf_flag)
  );

  fpx_irq_ctl #(.N_EXC(N_EXC)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init_cmd),
    .ack_i       (irq_ack),
    .flags_nxt_i (flags_nxt),
    .mask_nxt_i  (cw_nxt[N_EXC-1:0]),
    .irq_o       (irq_q)
  );

  always_comb begin
    evt_eff              = evt_pulse;
    evt_eff[INVALID_POS] = evt_pulse[INVALID_POS] | evt_stack_fault;
  end

  always_comb begin
    stat_word                = '0;
    stat_word[N_EXC-1:0]     = flags;
    stat_word[STK_FAULT_POS] = sf_flag;
    stat_word[IRQ_POS]       = irq_q;
  end

  assign ctl_word      = cw_q;
  assign round_mode    = cw_q[RND_LSB +: RND_W];
  assign subst_default = evt_eff & cw_q[N_EXC-1:0];
  assign irq_req       = irq_q;
endmodule

// File: rtl/fpx_guard_chk.sv
module fpx_guard_chk #(
  parameter int unsigned N_EXC = 6,
  parameter int unsigned WORD_W = 16,
  parameter logic [WORD_W-1:0] CW_RESET = 16'h037F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_cmd,
  input logic              clear_cmd,
  input logic [N_EXC-1:0]  evt_pulse,
  input logic              evt_stack_fault,
  input logic [WORD_W-1:0] ctl_word,
  input logic [WORD_W-1:0] stat_word,
  input logic              irq_req
);
  p_init_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init_cmd |=> (ctl_word == CW_RESET) && (stat_word == '0) && !irq_req);

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt_pulse) && !init_cmd) |=>
      ((stat_word[N_EXC-1:0] & $past(evt_pulse)) == $past(evt_pulse)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_cmd && !clear_cmd) |=>
      ((stat_word[N_EXC-1:0] & $past(stat_word[N_EXC-1:0])) == $past(stat_word[N_EXC-1:0])));

  p_sf_with_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stack_fault && !init_cmd) |=> (stat_word[6] && stat_word[0]));

  p_rise_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> (|(stat_word[N_EXC-1:0] & ~ctl_word[N_EXC-1:0])));

  p_ack_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && (|(stat_word[N_EXC-1:0] & ~ctl_word[N_EXC-1:0])) && !init_cmd) |=> irq_req);

  p_ir_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[7] == irq_req) && (stat_word[WORD_W-1:8] == '0));
endmodule

bind fpx_guard fpx_guard_chk #(.N_EXC(N_EXC), .WORD_W(WORD_W), .CW_RESET(CW_RESET)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .init_cmd        (init_cmd),
  .clear_cmd       (clear_cmd),
  .evt_pulse       (evt_pulse),
  .evt_stack_fault (evt_stack_fault),
  .ctl_word        (ctl_word),
  .stat_word       (stat_word),
  .irq_req         (irq_req)
);

// File: tb/tb_fpx_guard.sv
module tb_fpx_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        init_cmd;
  logic        clear_cmd;
  logic        irq_ack;
  logic        ctl_wr_en;
  logic [15:0] ctl_wr_data;
  logic [5:0]  evt_pulse;
  logic        evt_stack_fault;
  logic [15:0] ctl_word;
  logic [15:0] stat_word;
  logic [1:0]  round_mode;
  logic [5:0]  subst_default;
  logic        irq_req;

  int checks;
  int errors;
  bit done;

  fpx_guard dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .init_cmd        (init_cmd),
    .clear_cmd       (clear_cmd),
    .irq_ack         (irq_ack),
    .ctl_wr_en       (ctl_wr_en),
    .ctl_wr_data     (ctl_wr_data),
    .evt_pulse       (evt_pulse),
    .evt_stack_fault (evt_stack_fault),
    .ctl_word        (ctl_word),
    .stat_word       (stat_word),
    .round_mode      (round_mode),
    .subst_default   (subst_default),
    .irq_req         (irq_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive all inputs at the falling edge, then let combinational outputs settle
  task automatic drive(input logic ini, input logic clr, input logic ack,
                       input logic wr, input logic [15:0] wd,
                       input logic [5:0] ev, input logic sf);
    @(negedge clk);
    init_cmd = ini; clear_cmd = clr; irq_ack = ack;
    ctl_wr_en = wr; ctl_wr_data = wd; evt_pulse = ev; evt_stack_fault = sf;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    drive(0, 0, 0, 0, 16'h0, 6'h0, 0);
  endtask

  task automatic t_reset();
    chk("R1 ctl after reset", ctl_word, 16'h037F);
    chk("R1 stat after reset", stat_word, 16'h0000);
    chk("R1 irq after reset", {15'h0, irq_req}, 16'h0);
    chk("R7 rounding after reset", {14'h0, round_mode}, 16'h0);
  endtask

  task automatic t_masked_events();
    for (int i = 0; i < 6; i++) begin
      drive(0, 0, 0, 0, 16'h0, 6'(1 << i), 0);
      chk("R5 subst on masked event", {10'h0, subst_default}, 16'(1 << i));
      tick();
      chk("R2 flag set", {15'h0, stat_word[i]}, 16'h1);
      chk("R5 no irq when masked", {15'h0, irq_req}, 16'h0);
      quiet();
    end
    tick();
    chk("R2 sticky all flags", stat_word, 16'h003F);
    drive(0, 1, 0, 0, 16'h0, 6'h0, 0);
    tick();
    chk("R4 clear flags", stat_word, 16'h0000);
    quiet();
  endtask

  task automatic t_stack_fault();
    drive(0, 0, 0, 0, 16'h0, 6'h0, 1);
    chk("R5 stack fault counts as masked invalid", {10'h0, subst_default}, 16'h0001);
    tick();
    chk("R3 stack fault bits", stat_word, 16'h0041);
    drive(0, 1, 0, 0, 16'h0, 6'h0, 0);
    tick();
    chk("R4 clear stack fault", stat_word, 16'h0000);
    quiet();
  endtask

  task automatic t_unmasked();
    drive(0, 0, 0, 1, 16'h037B, 6'h0, 0);
    tick();
    chk("R7 ctl write", ctl_word, 16'h037B);
    chk("R7 no irq without flag", {15'h0, irq_req}, 16'h0);
    drive(0, 0, 0, 0, 16'h0, 6'h04, 0);
    chk("R6 no subst when unmasked", {10'h0, subst_default}, 16'h0);
    tick();
    chk("R6 irq on unmasked event", stat_word, 16'h0084);
    chk("R10 irq mirrors bit7", {15'h0, irq_req}, 16'h1);
    drive(0, 0, 1, 0, 16'h0, 6'h0, 0);
    tick();
    chk("R8 ack ignored while pending", {15'h0, irq_req}, 16'h1);
    drive(0, 1, 0, 0, 16'h0, 6'h0, 0);
    tick();
    chk("R4 clear keeps IR", stat_word, 16'h0080);
    drive(0, 0, 1, 0, 16'h0, 6'h0, 0);
    tick();
    chk("R8 ack clears IR", stat_word, 16'h0000);
    drive(0, 0, 0, 1, 16'h037F, 6'h0, 0);
    tick();
    quiet();
  endtask

  task automatic t_unmask_late();
    drive(0, 0, 0, 0, 16'h0, 6'h08, 0);
    tick();
    chk("R5 masked overflow", stat_word, 16'h0008);
    drive(0, 0, 0, 1, 16'h0377, 6'h0, 0);
    tick();
    chk("R7 unmask pending flag raises IR", stat_word, 16'h0088);
    drive(0, 0, 0, 1, 16'h037F, 6'h0, 0);
    tick();
    chk("R8 IR held after remask", {15'h0, irq_req}, 16'h1);
    drive(0, 0, 1, 0, 16'h0, 6'h0, 0);
    tick();
    chk("R8 ack after remask", stat_word, 16'h0008);
    drive(0, 1, 0, 0, 16'h0, 6'h0, 0);
    tick();
    quiet();
  endtask

  task automatic t_rounding();
    drive(0, 0, 0, 1, 16'h0C7F, 6'h0, 0);
    tick();
    chk("R7 rounding mode 3", {14'h0, round_mode}, 16'h3);
    drive(0, 0, 0, 1, 16'h047F, 6'h0, 0);
    tick();
    chk("R7 rounding mode 1", {14'h0, round_mode}, 16'h1);
    quiet();
  endtask

  task automatic t_clear_with_event();
    drive(0, 1, 0, 0, 16'h0, 6'h20, 0);
    tick();
    chk("R4 event beats clear", stat_word, 16'h0020);
    quiet();
  endtask

  task automatic t_init_priority();
    drive(0, 0, 0, 1, 16'h0040, 6'h02, 0);
    tick();
    chk("R6 irq before init", {15'h0, irq_req}, 16'h1);
    drive(1, 1, 1, 1, 16'h0000, 6'h3F, 1);
    tick();
    chk("R9 init ctl", ctl_word, 16'h037F);
    chk("R9 init stat", stat_word, 16'h0000);
    chk("R1 init irq", {15'h0, irq_req}, 16'h0);
    quiet();
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0;
    init_cmd = 0; clear_cmd = 0; irq_ack = 0; ctl_wr_en = 0;
    ctl_wr_data = 16'h0; evt_pulse = 6'h0; evt_stack_fault = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_masked_events();
    t_stack_fault();
    t_unmasked();
    t_unmask_late();
    t_rounding();
    t_clear_with_event();
    t_init_priority();
    tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule